// File: doc/BRIEF.md
# Repeated String Compare and Scan Engine

This block runs the repeated compare and scan string operations of a processor execution unit. A compare walks two memory strings, one at a source pointer and one at a destination pointer. A scan walks one string at the destination pointer and checks each element against an accumulator value. An operation repeats either while the elements are equal or while they differ, and it ends when the count runs out or when an element breaks that condition. Elements are 1, 2 or 4 bytes wide.

One pulse on `start_i` begins an invocation. The engine reads memory through a request port that returns either data or an abort. It then presents the updated count and pointers, the flags of the last subtraction and the cost spent. It also gives a one-cycle `done_o`, with `restart_o` set when the sequencer must issue the instruction again. A compare invocation handles at most one element. A scan invocation loops until a cycle budget is exceeded. The sequencer feeds the returned registers back in for the next invocation.

Top module: `strscan_engine`

## Requirements
- R1: An element is processed only while the count is nonzero and the zero state equals the mode bit `rep_eq_i` (1 = repeat while equal, 0 = repeat while not equal). The zero state is preset to the mode bit at start. A start with count 0 issues no memory read, returns at once and leaves the flags unchanged.
- R2: Compare computes source element minus destination element. Scan computes accumulator minus memory element. Both use only the low 8/16/32 bits for size codes 0/1/2. The flags are zf (zero result), sf (result MSB), cf (borrow), of (signed overflow) and pf (1 when the low result byte has an even number of ones).
- R3: A compare invocation processes at most one element. `restart_o` is high during `done_o` exactly when, after that element, the count is nonzero and zf equals the mode bit.
- R4: A scan invocation keeps processing elements until the condition of R1 fails or the cost accumulated in the invocation exceeds BUDGET (1000). With `trap_i` set it processes exactly one element.
- R5: Each element costs 7 (fast_i=1) or 9 cycles for compare, and 5 (fast_i=1) or 8 cycles for scan. `cost_o` reports the sum over the invocation.
- R6: For each element the count decrements by one. The pointers in use move by 1, 2 or 4 (size codes 0, 1, 2): downward when `dir_down_i` = 1, upward otherwise. Scan leaves the source pointer unchanged.
- R7: A memory abort ends the invocation with `fault_o` = 1 and `restart_o` = 0. The count, pointers and flags keep the values they had before that element.
- R8: Compare reads the source element first and then the destination element. A request holds its address and size until ack or abort. The element data is taken from the low-order bytes of `mem_rdata_i`.
- R9: After reset `done_o`, `restart_o`, `mem_req_o` and `count_o` are 0. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin an invocation (taken when idle) |
| op_scan_i | input | 1 | 1 = scan, 0 = compare |
| rep_eq_i | input | 1 | 1 = repeat while equal, 0 = while not equal |
| size_i | input | 2 | Element size code: 0 byte, 1 half, 2 word |
| fast_i | input | 1 | Selects the faster per-element cost |
| trap_i | input | 1 | Single-step: scan handles one element |
| dir_down_i | input | 1 | Pointers decrement when 1 |
| count_i | input | CW | Remaining element count |
| src_ptr_i | input | AW | Source pointer |
| dst_ptr_i | input | AW | Destination pointer |
| acc_i | input | 32 | Accumulator for scan |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read address |
| mem_size_o | output | 2 | Read size code |
| mem_ack_i | input | 1 | Read data valid |
| mem_abort_i | input | 1 | Read aborted |
| mem_rdata_i | input | 32 | Read data, element in low bytes |
| done_o | output | 1 | Invocation finished (one cycle) |
| restart_o | output | 1 | Instruction must be issued again |
| fault_o | output | 1 | Invocation ended by abort |
| count_o | output | CW | Updated count |
| src_ptr_o | output | AW | Updated source pointer |
| dst_ptr_o | output | AW | Updated destination pointer |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Borrow flag |
| of_o | output | 1 | Overflow flag |
| pf_o | output | 1 | Parity flag |
| cost_o | output | COSTW | Cycles charged this invocation |

## Verification
The assertions assume that the memory side answers only while a request is pending, and never with ack and abort in the same cycle. They also assume that `start_i` arrives only while the engine is idle and that size code 3 is never used. The bench memory model follows these rules: ack or abort is derived from the pending request in the same cycle, and the abort target is chosen by address. The bench waits for `done_o` before the next start and drives only size codes 0 to 2.

// File: rtl/strscan_pkg.sv
package strscan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RD_A, ST_RD_B, ST_DONE
  } st_t;

  typedef struct packed {
    logic zf;
    logic sf;
    logic cf;
    logic ov;
    logic pf;
  } flags_t;

  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic msb_at(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    return v[7];
      2'd1:    return v[15];
      default: return v[31];
    endcase
  endfunction

  // a and b must already be masked to the element width
  function automatic flags_t sub_flags(input logic [31:0] a, input logic [31:0] b,
                                       input logic [1:0] sz);
    flags_t f;
    logic [31:0] r;
    r    = (a - b) & width_mask(sz);
    f.zf = (r == 32'd0);
    f.sf = msb_at(r, sz);
    f.cf = (a < b);
    f.ov = (msb_at(a, sz) != msb_at(b, sz)) && (msb_at(r, sz) != msb_at(a, sz));
    f.pf = ~^r[7:0];
    return f;
  endfunction

endpackage

// File: rtl/strscan_alu.sv
module strscan_alu
  import strscan_pkg::*;
(
  input  logic [31:0] lhs,
  input  logic [31:0] rhs,
  input  logic [1:0]  sz,
  output flags_t      flg
);
  logic [31:0] lhs_m, rhs_m;
  always_comb begin
    lhs_m = lhs & width_mask(sz);
    rhs_m = rhs & width_mask(sz);
    flg   = sub_flags(lhs_m, rhs_m, sz);
  end
endmodule

// File: rtl/strscan_step.sv
module strscan_step
  import strscan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    sz,
  input  logic          down,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;
  always_comb begin
    step = {{(AW-3){1'b0}}, step_bytes(sz)};
    nxt  = down ? ptr - step : ptr + step;
  end
endmodule

// File: rtl/strscan_budget.sv
module strscan_budget #(
  parameter int COSTW  = 16,
  parameter int BUDGET = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [COSTW-1:0] cost,
  output logic [COSTW-1:0] spent,
  output logic             over_nx
);
  localparam logic [COSTW-1:0] LIMIT = COSTW'(BUDGET);
  logic [COSTW-1:0] spent_nx;

  assign spent_nx = spent + cost;
  assign over_nx  = spent_nx > LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   spent <= '0;
    else if (clr) spent <= '0;
    else if (add) spent <= spent_nx;
  end
endmodule

// File: rtl/strscan_engine.sv
module strscan_engine
  import strscan_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CW          = 32,
  parameter int COSTW       = 16,
  parameter int BUDGET      = 1000,
  parameter int CMP_FAST_C  = 7,
  parameter int CMP_SLOW_C  = 9,
  parameter int SCAN_FAST_C = 5,
  parameter int SCAN_SLOW_C = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_scan_i,
  input  logic             rep_eq_i,
  input  logic [1:0]       size_i,
  input  logic             fast_i,
  input  logic             trap_i,
  input  logic             dir_down_i,
  input  logic [CW-1:0]    count_i,
  input  logic [AW-1:0]    src_ptr_i,
  input  logic [AW-1:0]    dst_ptr_i,
  input  logic [31:0]      acc_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [1:0]       mem_size_o,
  input  logic             mem_ack_i,
  input  logic             mem_abort_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             done_o,
  output logic             restart_o,
  output logic             fault_o,
  output logic [CW-1:0]    count_o,
  output logic [AW-1:0]    src_ptr_o,
  output logic [AW-1:0]    dst_ptr_o,
  output logic             zf_o,
  output logic             sf_o,
  output logic             cf_o,
  output logic             of_o,
  output logic             pf_o,
  output logic [COSTW-1:0] cost_o
);
  localparam int MAXC = (CMP_SLOW_C > SCAN_SLOW_C) ? CMP_SLOW_C : SCAN_SLOW_C;

  st_t           st;
  logic          op_scan_q, mode_q, fast_q, trap_q, dir_q, zt_q, fault_q;
  logic [1:0]    size_q;
  logic [31:0]   acc_q, opa_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, dst_q, src_nx, dst_nx;
  flags_t        flags_q, alu_f;
  logic [31:0]   alu_lhs;
  logic [COSTW-1:0] elem_cost;
  logic          over_nx;

  // named events for the checker
  logic busy, start_acc, loop_ok, elem_done, abort_evt;

  assign busy      = (st != ST_IDLE);
  assign start_acc = start_i && !busy;
  assign loop_ok   = (cnt_q != '0) && (zt_q == mode_q);
  assign elem_done = (st == ST_RD_B) && mem_ack_i;
  assign abort_evt = mem_req_o && mem_abort_i;

  assign alu_lhs   = op_scan_q ? acc_q : opa_q;
  assign elem_cost = op_scan_q ? COSTW'(fast_q ? SCAN_FAST_C : SCAN_SLOW_C)
                               : COSTW'(fast_q ? CMP_FAST_C  : CMP_SLOW_C);

  strscan_alu u_alu (.lhs(alu_lhs), .rhs(mem_rdata_i), .sz(size_q), .flg(alu_f));

  strscan_step #(.AW(AW)) u_src_step (.ptr(src_q), .sz(size_q), .down(dir_q), .nxt(src_nx));
  strscan_step #(.AW(AW)) u_dst_step (.ptr(dst_q), .sz(size_q), .down(dir_q), .nxt(dst_nx));

  strscan_budget #(.COSTW(COSTW), .BUDGET(BUDGET)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .add(elem_done),
    .cost(elem_cost), .spent(cost_o), .over_nx(over_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_scan_q <= 1'b0;
      mode_q    <= 1'b0;
      fast_q    <= 1'b0;
      trap_q    <= 1'b0;
      dir_q     <= 1'b0;
      size_q    <= 2'd0;
      acc_q     <= '0;
      opa_q     <= '0;
      cnt_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      zt_q      <= 1'b0;
      fault_q   <= 1'b0;
      flags_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_i) begin
          op_scan_q <= op_scan_i;
          mode_q    <= rep_eq_i;
          fast_q    <= fast_i;
          trap_q    <= trap_i;
          dir_q     <= dir_down_i;
          size_q    <= size_i;
          acc_q     <= acc_i;
          cnt_q     <= count_i;
          src_q     <= src_ptr_i;
          dst_q     <= dst_ptr_i;
          zt_q      <= rep_eq_i;
          fault_q   <= 1'b0;
          st        <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!loop_ok)       st <= ST_DONE;
          else if (op_scan_q) st <= ST_RD_B;
          else                st <= ST_RD_A;
        end
        ST_RD_A: begin
          if (mem_abort_i) begin
            fault_q <= 1'b1;
            st      <= ST_DONE;
          end else if (mem_ack_i) begin
            opa_q <= mem_rdata_i;
            st    <= ST_RD_B;
          end
        end
        ST_RD_B: begin
          if (mem_abort_i) begin
            fault_q <= 1'b1;
            st      <= ST_DONE;
          end else if (mem_ack_i) begin
            flags_q <= alu_f;
            zt_q    <= alu_f.zf;
            cnt_q   <= cnt_q - CW'(1);
            dst_q   <= dst_nx;
            if (!op_scan_q) src_q <= src_nx;
            st <= (op_scan_q && !trap_q && !over_nx) ? ST_CHECK : ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st == ST_RD_A) || (st == ST_RD_B);
  assign mem_addr_o = (st == ST_RD_A) ? src_q : dst_q;
  assign mem_size_o = size_q;
  assign done_o     = (st == ST_DONE);
  assign restart_o  = done_o && !fault_q && loop_ok;
  assign fault_o    = fault_q;
  assign count_o    = cnt_q;
  assign src_ptr_o  = src_q;
  assign dst_ptr_o  = dst_q;
  assign zf_o       = flags_q.zf;
  assign sf_o       = flags_q.sf;
  assign cf_o       = flags_q.cf;
  assign of_o       = flags_q.ov;
  assign pf_o       = flags_q.pf;
endmodule

// File: rtl/strscan_engine_chk.sv
module strscan_engine_chk #(
  parameter int AW     = 32,
  parameter int CW     = 32,
  parameter int COSTW  = 16,
  parameter int BUDGET = 1000,
  parameter int MAXC   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_acc,
  input logic             elem_done,
  input logic             abort_evt,
  input logic             op_scan_q,
  input logic             trap_q,
  input logic             mode_q,
  input logic             done_o,
  input logic             restart_o,
  input logic [CW-1:0]    count_o,
  input logic [AW-1:0]    src_ptr_o,
  input logic [AW-1:0]    dst_ptr_o,
  input logic             zf_o,
  input logic [COSTW-1:0] cost_o,
  input logic             mem_req_o,
  input logic             mem_ack_i,
  input logic             mem_abort_i,
  input logic [AW-1:0]    mem_addr_o
);
  logic [15:0] elems;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          elems <= '0;
    else if (start_acc)                  elems <= '0;
    else if (elem_done && elems != '1)   elems <= elems + 16'd1;
  end

  // R6
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> count_o == $past(count_o) - CW'(1));

  // R3
  cmp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !op_scan_q) |-> elems <= 16'd1);

  // R4
  trap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && trap_q) |-> elems <= 16'd1);

  // R5
  cost_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cost_o <= COSTW'(BUDGET + MAXC));

  // R1
  restart_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (count_o != '0) && (zf_o == mode_q));

  // R7
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> $stable(count_o) && $stable(src_ptr_o) && $stable(dst_ptr_o) && done_o);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !mem_abort_i) |=> mem_req_o && $stable(mem_addr_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind strscan_engine strscan_engine_chk #(
  .AW(AW), .CW(CW), .COSTW(COSTW), .BUDGET(BUDGET), .MAXC(MAXC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .elem_done(elem_done),
  .abort_evt(abort_evt), .op_scan_q(op_scan_q), .trap_q(trap_q), .mode_q(mode_q),
  .done_o(done_o), .restart_o(restart_o), .count_o(count_o), .src_ptr_o(src_ptr_o),
  .dst_ptr_o(dst_ptr_o), .zf_o(zf_o), .cost_o(cost_o), .mem_req_o(mem_req_o),
  .mem_ack_i(mem_ack_i), .mem_abort_i(mem_abort_i), .mem_addr_o(mem_addr_o)
);

// File: tb/strscan_engine_tb_top.sv
`timescale 1ns/1ps
module strscan_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start_i = 0, op_scan_i = 0, rep_eq_i = 0, fast_i = 0, trap_i = 0, dir_down_i = 0;
  logic [1:0]  size_i = 0;
  logic [31:0] count_i = 0, src_ptr_i = 0, dst_ptr_i = 0, acc_i = 0;
  logic        mem_req_o, mem_ack_i, mem_abort_i;
  logic [31:0] mem_addr_o, mem_rdata_i;
  logic [1:0]  mem_size_o;
  logic        done_o, restart_o, fault_o, zf_o, sf_o, cf_o, of_o, pf_o;
  logic [31:0] count_o, src_ptr_o, dst_ptr_o;
  logic [15:0] cost_o;

  strscan_engine dut_i (.*);

  logic [7:0] mem [256];
  logic       abort_en = 0;
  logic [7:0] abort_at = 0;

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    logic [7:0] b = a[7:0];
    return {mem[b + 8'd3], mem[b + 8'd2], mem[b + 8'd1], mem[b]};
  endfunction

  always_comb begin
    mem_rdata_i = rd_word(mem_addr_o);
    mem_abort_i = mem_req_o && abort_en && (mem_addr_o[7:0] == abort_at);
    mem_ack_i   = mem_req_o && !mem_abort_i;
  end

  int n_chk = 0, n_bad = 0, n_req = 0;
  logic [31:0] req_log [4];
  always @(negedge clk) if (mem_req_o) begin
    if (n_req < 4) req_log[n_req] = mem_addr_o;
    n_req++;
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic invoke(input logic op, input logic md, input logic [1:0] sz,
                        input logic dn, input logic fs, input logic tr,
                        input logic [31:0] cn, input logic [31:0] sp,
                        input logic [31:0] dp, input logic [31:0] ac);
    int guard = 0;
    @(negedge clk);
    op_scan_i = op; rep_eq_i = md; size_i = sz; dir_down_i = dn; fast_i = fs;
    trap_i = tr; count_i = cn; src_ptr_i = sp; dst_ptr_i = dp; acc_i = ac;
    n_req = 0;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (!done_o && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (!done_o) check("R9 done timeout", 0, 1);
  endtask

  typedef struct packed {
    logic        op;
    logic        md;
    logic [1:0]  sz;
    logic        dn;
    logic [7:0]  sp;
    logic [7:0]  dp;
    logic [15:0] cn;
    logic [31:0] ac;
    logic [15:0] ecn;
    logic        ezf;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{1'b0, 1'b1, 2'd0, 1'b0, 8'h00, 8'h80, 16'd10,  32'h0,         16'd4,  1'b0},
    '{1'b0, 1'b1, 2'd1, 1'b0, 8'h00, 8'h80, 16'd8,   32'h0,         16'd5,  1'b0},
    '{1'b0, 1'b1, 2'd2, 1'b1, 8'h0C, 8'h8C, 16'd4,   32'h0,         16'd1,  1'b0},
    '{1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'h80, 16'd3,   32'h0,         16'd2,  1'b1},
    '{1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 8'h00, 16'd20,  32'h0000_0007, 16'd12, 1'b1},
    '{1'b1, 1'b1, 2'd0, 1'b0, 8'h00, 8'h00, 16'd20,  32'h0,         16'd18, 1'b0},
    '{1'b1, 1'b0, 2'd1, 1'b0, 8'h00, 8'h00, 16'd10,  32'h0000_0B0A, 16'd4,  1'b1},
    '{1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 8'h00, 16'd300, 32'h1234_56FF, 16'd0,  1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i]       = 8'(i);
      mem[128 + i] = 8'(i);
    end
    mem[133] = 8'hEE;

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 done after reset", done_o, 0);
    check("R9 restart after reset", restart_o, 0);
    check("R9 mem_req after reset", mem_req_o, 0);
    check("R9 count after reset", count_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // vector table: chained invocations until no restart (R1 R2 R3 R4 R6)
    foreach (VT[k]) begin
      logic [31:0] cn, sp, dp, n, off, esp, edp;
      int iters = 0;
      cn = 32'(VT[k].cn); sp = 32'(VT[k].sp); dp = 32'(VT[k].dp);
      invoke(VT[k].op, VT[k].md, VT[k].sz, VT[k].dn, 1'b1, 1'b0, cn, sp, dp, VT[k].ac);
      while (restart_o && iters < 400) begin
        invoke(VT[k].op, VT[k].md, VT[k].sz, VT[k].dn, 1'b1, 1'b0,
               count_o, src_ptr_o, dst_ptr_o, VT[k].ac);
        iters++;
      end
      n   = cn - 32'(VT[k].ecn);
      off = n << VT[k].sz;
      edp = VT[k].dn ? dp - off : dp + off;
      esp = VT[k].op ? sp : (VT[k].dn ? sp - off : sp + off);
      check("R1 final count", count_o, 32'(VT[k].ecn));
      check("R2 final zf", zf_o, VT[k].ezf);
      check("R6 final dst pointer", dst_ptr_o, edp);
      check("R6 final src pointer", src_ptr_o, esp);
    end

    // R2 flags of a byte compare 0x05 - 0xEE
    invoke(0, 1, 2'd0, 0, 1, 0, 1, 32'h05, 32'h85, 0);
    check("R2 zf", zf_o, 0);
    check("R2 cf", cf_o, 1);
    check("R2 sf", sf_o, 0);
    check("R2 of", of_o, 0);
    check("R2 pf", pf_o, 1);

    // R2 overflow: scan 0x80 - 0x01
    invoke(1, 1, 2'd0, 0, 1, 0, 1, 0, 32'h01, 32'hFFFF_FF80);
    check("R2 overflow of", of_o, 1);
    check("R2 overflow cf", cf_o, 0);
    check("R2 overflow sf", sf_o, 0);
    check("R2 overflow pf", pf_o, 0);

    // R1 count zero: no read, flags untouched
    invoke(0, 1, 2'd0, 0, 1, 0, 0, 32'h10, 32'h90, 0);
    check("R1 no read on zero count", 32'(n_req), 0);
    check("R1 restart on zero count", restart_o, 0);
    check("R1 flags kept on zero count", of_o, 1);
    check("R5 cost on zero count", 32'(cost_o), 0);

    // R7 abort on the destination read
    abort_en = 1; abort_at = 8'h82;
    invoke(0, 1, 2'd0, 0, 1, 0, 8, 32'h02, 32'h82, 0);
    check("R7 fault", fault_o, 1);
    check("R7 no restart", restart_o, 0);
    check("R7 count held", count_o, 8);
    check("R7 src held", src_ptr_o, 32'h02);
    check("R7 dst held", dst_ptr_o, 32'h82);
    check("R7 flags held", of_o, 1);
    abort_en = 0;

    // R8 read order and R3/R5 compare cost
    invoke(0, 1, 2'd0, 0, 0, 0, 5, 32'h10, 32'h90, 0);
    check("R8 read count", 32'(n_req), 2);
    check("R8 first read source", req_log[0], 32'h10);
    check("R8 second read destination", req_log[1], 32'h90);
    check("R3 restart after equal compare", restart_o, 1);
    check("R3 one element", count_o, 4);
    check("R5 compare slow cost", 32'(cost_o), 9);
    check("R7 no fault", fault_o, 0);
    invoke(0, 1, 2'd0, 0, 1, 0, 5, 32'h10, 32'h90, 0);
    check("R5 compare fast cost", 32'(cost_o), 7);

    // R5 scan costs (8 elements)
    invoke(1, 0, 2'd0, 0, 1, 0, 20, 0, 0, 32'h07);
    check("R5 scan fast cost", 32'(cost_o), 40);
    invoke(1, 0, 2'd0, 0, 0, 0, 20, 0, 0, 32'h07);
    check("R5 scan slow cost", 32'(cost_o), 64);

    // R4 budget
    invoke(1, 0, 2'd0, 0, 1, 0, 300, 0, 0, 32'hFF);
    check("R4 budget fast count", count_o, 99);
    check("R4 budget fast restart", restart_o, 1);
    check("R5 budget fast cost", 32'(cost_o), 1005);
    invoke(1, 0, 2'd0, 0, 0, 0, 300, 0, 0, 32'hFF);
    check("R4 budget slow count", count_o, 174);
    check("R4 budget slow restart", restart_o, 1);

    // R4 trap single element
    invoke(1, 0, 2'd0, 0, 1, 1, 300, 0, 0, 32'hFF);
    check("R4 trap count", count_o, 299);
    check("R4 trap restart", restart_o, 1);
    check("R4 trap reads", 32'(n_req), 1);

    // R9 done is a pulse
    @(negedge clk);
    check("R9 done pulse", done_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule